// File: doc/BRIEF.md
# Seven-Level Multicarrier PWM Modulator

This block produces the five gate enables for one leg of a seven-level inverter built from four series DC sources. Two switches select output polarity and three select the step magnitude, so no H-bridge is needed. A sampled sine reference comes from a phase accumulator and a quarter-wave table, and a modulation index scales it. The scaled reference is compared against six triangular carriers stacked in equal bands across the full reference span. The number of active comparators gives a signed output level from -3 to +3, and that level is decoded into a gate pattern.

At run time the carriers can be arranged in one of three ways. All six can be in phase. The upper three can mirror the lower three. Or each carrier can run in opposite phase to its neighbour. A change of arrangement waits for the next carrier period boundary. A programmable dead time keeps both polarity switches off for a set number of clocks after the output changes sign. Two programmable phase-increment words set the sine frequency and the carrier frequency. Driving the enable low forces every gate off and restarts both accumulators from zero phase.

Top module: `mlpwm_modulator`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `en` is sampled low, `gate_o` and `level_o` are zero. Both phase accumulators restart from zero, so the first enabled clock loads exactly one increment into each.
- R2: Carrier k (k = 0..5) sweeps its band from (k-3)*B to (k-3)*B+B-1, where B = 2^TRI_W (1024 by default). The reference is floor(s*mod_idx*3 / 2^(15+MI_W-TRI_W)), where s is the signed 16-bit sine sample with a full-scale value of 32767. Because the bands are stacked, the comparator results form a thermometer code.
- R3: `mode_sel` = 0 and `mode_sel` = 3 select the in-phase arrangement. Every carrier rises from its band bottom during the first half of each carrier period.
- R4: `mode_sel` = 1 selects the mirrored arrangement. Carriers 3..5 rise in the first half-period and carriers 0..2 fall from their band tops.
- R5: `mode_sel` = 2 selects the alternating arrangement. Even-numbered carriers rise and odd-numbered carriers fall in the first half-period.
- R6: The signed level equals the number of carriers that the reference strictly exceeds, minus 3. With a constant reference inside one band, only the two levels adjacent to that band appear.
- R7: A new `mode_sel` value takes effect only when the carrier phase accumulator wraps, or while `en` is low.
- R8: `gate_o` bit i drives switch S(i+1). The level-to-gate mapping is: +1 → S3,S5; +2 → S2,S5; +3 → S1,S5; 0 → none; -1 → S1,S4; -2 → S2,S4; -3 → S3,S4. `level_o` is aligned in time with `gate_o`.
- R9: S5 is on only at positive levels and S4 only at negative levels, so the two are never on together. At any nonzero level exactly one of S1..S3 is on.
- R10: When the level becomes nonzero with the opposite sign to the last nonzero level, S4 and S5 are held off for `dead_time` clocks. This blanking starts in the cycle where the new sign first appears on `level_o`.
- R11: With a running sine at full modulation index, the output visits both +3 and -3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low forces gates off and zeroes phases |
| mode_sel | input | 2 | Carrier arrangement: 0/3 in phase, 1 mirrored, 2 alternating |
| mod_idx | input | MI_W | Modulation index, value/2^MI_W of full scale |
| sine_inc | input | PH_W | Sine phase increment per clock |
| car_inc | input | PH_W | Carrier phase increment per clock |
| dead_time | input | DT_W | Polarity blanking length in clocks |
| gate_o | output | 5 | Gate enables, bit 0 = S1 ... bit 4 = S5 |
| level_o | output | 3 | Signed output level, -3..+3 |

## Verification
The reference is frozen at a chosen constant, at half of the top band or half of the second-lowest band. The level is then read early and late in the carrier period. Under each arrangement these readings come out in a different order, so the positive reference separates the alternating arrangement from the others, and the negative reference separates the in-phase arrangement from the mirrored one. A full carrier period at that constant reference checks the duty and confirms that only two levels appear. A mid-period mode change shows the latching at the period boundary. A free-running sine with dead time checks every gate pattern against the table, confirms the polarity exclusion, and covers the blanking windows at each zero crossing.

// File: rtl/mlpwm_pkg.sv
// Shared types and constant functions for the multicarrier modulator.
// Assumes seven output levels; the gate table below is fixed to that count.
package mlpwm_pkg;

    localparam int LEVELS  = 7;
    localparam int NUM_CAR = LEVELS - 1;
    localparam int HALF    = NUM_CAR / 2;

    typedef enum logic [1:0] {
        DISP_INPHASE = 2'd0,
        DISP_MIRROR  = 2'd1,
        DISP_ALTERN  = 2'd2,
        DISP_SPARE   = 2'd3
    } disp_e;

    typedef logic signed [2:0] level_t;

    // Gate vector {S5,S4,S3,S2,S1} for a signed level.
    function automatic logic [4:0] level_to_gates(input level_t lv);
        case (lv)
            3'sd1:   return 5'b10100;
            3'sd2:   return 5'b10010;
            3'sd3:   return 5'b10001;
            -3'sd1:  return 5'b01001;
            -3'sd2:  return 5'b01010;
            -3'sd3:  return 5'b01100;
            default: return 5'b00000;
        endcase
    endfunction

    // Quarter-wave sine in Q15, index i covers i*90/16 degrees, 0..16.
    function automatic logic signed [15:0] qsine(input logic [4:0] i);
        case (i)
            5'd0:    return 16'sd0;
            5'd1:    return 16'sd3212;
            5'd2:    return 16'sd6393;
            5'd3:    return 16'sd9512;
            5'd4:    return 16'sd12539;
            5'd5:    return 16'sd15446;
            5'd6:    return 16'sd18204;
            5'd7:    return 16'sd20787;
            5'd8:    return 16'sd23170;
            5'd9:    return 16'sd25329;
            5'd10:   return 16'sd27245;
            5'd11:   return 16'sd28898;
            5'd12:   return 16'sd30273;
            5'd13:   return 16'sd31356;
            5'd14:   return 16'sd32137;
            5'd15:   return 16'sd32609;
            default: return 16'sd32767;
        endcase
    endfunction

endpackage

// File: rtl/mlpwm_phase_gen.sv
// Sine and carrier phase accumulators plus the arrangement latch.
// Assumes a carrier period boundary is the carry out of the carrier accumulator.
// Only the top phase bits leave this module.
module mlpwm_phase_gen
    import mlpwm_pkg::*;
#(
    parameter int PH_W  = 32,
    parameter int TRI_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PH_W-1:0]  sine_inc,
    input  logic [PH_W-1:0]  car_inc,
    input  logic [1:0]       mode_sel,
    output logic [5:0]       sine_top,
    output logic [TRI_W:0]   car_top,
    output disp_e            mode_q
);

    logic [PH_W-1:0] sine_ph;
    logic [PH_W-1:0] car_ph;
    logic [PH_W:0]   car_sum;

    // Carrier sum with carry, the carry marks a period boundary.
    always_comb car_sum = {1'b0, car_ph} + {1'b0, car_inc};

    // Advance both phases; latch arrangement at a boundary or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sine_ph <= '0;
            car_ph  <= '0;
            mode_q  <= disp_e'(mode_sel);
        end else begin
            sine_ph <= sine_ph + sine_inc;
            car_ph  <= car_sum[PH_W-1:0];
            if (car_sum[PH_W])
                mode_q <= disp_e'(mode_sel);
        end
    end

    assign sine_top = sine_ph[PH_W-1 -: 6];
    assign car_top  = car_ph[PH_W-1 -: TRI_W+1];

    // R7: arrangement only changes at a wrap, while idle or out of reset
    assert_mode_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> ($past(car_sum[PH_W]) || !$past(en) || !$past(rst_n)));

endmodule

// File: rtl/mlpwm_ref_stage.sv
// Builds the scaled sine reference from a quarter-wave table and folds the
// carrier phase into a triangle. Registers both with the arrangement.
// Assumes 15+MI_W >= TRI_W so that the scaling shift is not negative.
module mlpwm_ref_stage
    import mlpwm_pkg::*;
#(
    parameter int TRI_W = 10,
    parameter int MI_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [5:0]               sine_top,
    input  logic [TRI_W:0]           car_top,
    input  disp_e                    mode_in,
    input  logic [MI_W-1:0]          mod_idx,
    output logic signed [TRI_W+2:0]  ref_q,
    output logic [TRI_W-1:0]         tri_q,
    output disp_e                    mode_q
);

    localparam int REF_W  = TRI_W + 3;
    localparam int PROD_W = 16 + MI_W + 3;
    localparam int SHIFT  = 15 + MI_W - TRI_W;
    localparam logic signed [PROD_W-1:0] THREE = PROD_W'(3);

    logic [1:0]               quad;
    logic [4:0]               lidx;
    logic signed [15:0]       mag;
    logic signed [15:0]       sval;
    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] m_ext;
    logic signed [PROD_W-1:0] prod;
    logic [TRI_W-1:0]         tri_w;

    // Quarter-wave lookup with mirrored index and sign by quadrant.
    always_comb begin
        quad = sine_top[5:4];
        lidx = quad[0] ? (5'd16 - {1'b0, sine_top[3:0]}) : {1'b0, sine_top[3:0]};
        mag  = qsine(lidx);
        sval = quad[1] ? -mag : mag;
    end

    // Scale the sine by modulation index onto the three-band half span.
    always_comb begin
        s_ext = {{(PROD_W-16){sval[15]}}, sval};
        m_ext = {{(PROD_W-MI_W){1'b0}}, mod_idx};
        prod  = s_ext * m_ext * THREE;
    end

    // Fold the carrier phase into a rising-then-falling triangle.
    always_comb tri_w = car_top[TRI_W] ? ~car_top[TRI_W-1:0] : car_top[TRI_W-1:0];

    // Pipeline register for reference, triangle and arrangement.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ref_q  <= '0;
            tri_q  <= '0;
            mode_q <= DISP_INPHASE;
        end else begin
            ref_q  <= REF_W'(prod >>> SHIFT);
            tri_q  <= tri_w;
            mode_q <= mode_in;
        end
    end

endmodule

// File: rtl/mlpwm_carrier_bank.sv
// Six level-shifted carriers, their comparators and the level count.
// Assumes the triangle spans 0..2^TRI_W-1 and that the reference lies within
// the span of all six bands.
module mlpwm_carrier_bank
    import mlpwm_pkg::*;
#(
    parameter int TRI_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [TRI_W+2:0]  ref_q,
    input  logic [TRI_W-1:0]         tri_q,
    input  disp_e                    mode_q,
    output level_t                   level_q
);

    localparam int REF_W  = TRI_W + 3;
    localparam int BAND   = 1 << TRI_W;
    localparam int CNT_W  = $clog2(NUM_CAR + 1) + 1;

    logic [NUM_CAR-1:0]      cmp;
    logic signed [REF_W-1:0] car [NUM_CAR];
    logic [CNT_W-1:0]        ones;
    level_t                  level_n;

    for (genvar k = 0; k < NUM_CAR; k++) begin : g_car
        localparam logic signed [REF_W-1:0] OFFS = REF_W'((k - HALF) * BAND);
        logic             inv;
        logic [TRI_W-1:0] face;

        // Pick falling or rising sweep for this carrier by arrangement.
        always_comb begin
            case (mode_q)
                DISP_MIRROR: inv = (k < HALF);
                DISP_ALTERN: inv = (k % 2 == 1);
                default:     inv = 1'b0;
            endcase
            face = inv ? ~tri_q : tri_q;
        end

        assign car[k] = OFFS + $signed({{(REF_W-TRI_W){1'b0}}, face});
        assign cmp[k] = (ref_q > car[k]);
    end

    // Count active comparators and move the count to a signed level.
    always_comb begin
        ones = '0;
        for (int k = 0; k < NUM_CAR; k++)
            ones = ones + CNT_W'(cmp[k]);
        level_n = level_t'($signed(ones) - CNT_W'(HALF));
    end

    // Register the level.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            level_q <= '0;
        else
            level_q <= level_n;
    end

    // R2: stacked bands make the comparator word a thermometer code
    assert_stacked_bands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp + 1'b1) & cmp) == '0);

endmodule

// File: rtl/mlpwm_gate_drive.sv
// Decodes the level into five gates and blanks the polarity pair for a
// programmable time after each change of sign.
// Assumes a sign change is judged against the last nonzero level.
module mlpwm_gate_drive
    import mlpwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  level_t          level_q,
    input  logic [DT_W-1:0] dead_time,
    output logic [4:0]      gates_o,
    output level_t          level_o
);

    logic [1:0]      req_sign;
    logic [1:0]      last_sign;
    logic [DT_W-1:0] dt_cnt;
    logic            flip;
    logic            blank;
    logic [4:0]      base;

    // Classify the incoming level sign and detect a polarity flip.
    always_comb begin
        req_sign = (level_q > 0) ? 2'b01 : ((level_q < 0) ? 2'b10 : 2'b00);
        flip     = (req_sign != 2'b00) && (last_sign != 2'b00) && (req_sign != last_sign);
        blank    = (dt_cnt != '0) || (flip && dead_time != '0);
        base     = level_to_gates(level_q);
    end

    // Register gates and level together, run the dead-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            gates_o   <= '0;
            level_o   <= '0;
            last_sign <= 2'b00;
            dt_cnt    <= '0;
        end else begin
            gates_o <= blank ? (base & 5'b00111) : base;
            level_o <= level_q;
            if (req_sign != 2'b00)
                last_sign <= req_sign;
            if (flip)
                dt_cnt <= (dead_time == '0) ? '0 : dead_time - 1'b1;
            else if (dt_cnt != '0)
                dt_cnt <= dt_cnt - 1'b1;
        end
    end

    // R1: a low enable clears the outputs one clock later
    assert_idle_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gates_o == '0 && level_o == '0));

    // R9: upper polarity switch only at positive levels
    assert_upper_pol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gates_o[4] |-> (level_o > 0));

    // R9: lower polarity switch only at negative levels
    assert_lower_pol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gates_o[3] |-> (level_o < 0));

    // R9: exactly one step switch at any nonzero level
    assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != 0) |-> ($countones(gates_o[2:0]) == 1));

    // R8: zero level leaves every switch off
    assert_zero_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 0) |-> (gates_o == '0));

    // R10: while the dead-time count runs the polarity pair stays off
    assert_dead_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dt_cnt != '0) |=> (gates_o[4:3] == 2'b00));

endmodule

// File: rtl/mlpwm_modulator.sv
// Top of the seven-level multicarrier modulator: phase generation,
// reference and triangle stage, carrier comparison, gate decode.
// Assumes the inputs are synchronous to clk. Latency from phase to gates
// is four clocks.
module mlpwm_modulator
    import mlpwm_pkg::*;
#(
    parameter int PH_W  = 32,
    parameter int TRI_W = 10,
    parameter int MI_W  = 8,
    parameter int DT_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [1:0]      mode_sel,
    input  logic [MI_W-1:0] mod_idx,
    input  logic [PH_W-1:0] sine_inc,
    input  logic [PH_W-1:0] car_inc,
    input  logic [DT_W-1:0] dead_time,
    output logic [4:0]      gate_o,
    output logic [2:0]      level_o
);

    logic [5:0]              sine_top;
    logic [TRI_W:0]          car_top;
    disp_e                   mode_p;
    disp_e                   mode_r;
    logic signed [TRI_W+2:0] ref_q;
    logic [TRI_W-1:0]        tri_q;
    level_t                  level_q;
    level_t                  level_out;

    mlpwm_phase_gen #(.PH_W(PH_W), .TRI_W(TRI_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en),
        .sine_inc(sine_inc), .car_inc(car_inc), .mode_sel(mode_sel),
        .sine_top(sine_top), .car_top(car_top), .mode_q(mode_p)
    );

    mlpwm_ref_stage #(.TRI_W(TRI_W), .MI_W(MI_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .en(en),
        .sine_top(sine_top), .car_top(car_top), .mode_in(mode_p),
        .mod_idx(mod_idx), .ref_q(ref_q), .tri_q(tri_q), .mode_q(mode_r)
    );

    mlpwm_carrier_bank #(.TRI_W(TRI_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .en(en),
        .ref_q(ref_q), .tri_q(tri_q), .mode_q(mode_r), .level_q(level_q)
    );

    mlpwm_gate_drive #(.DT_W(DT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .en(en),
        .level_q(level_q), .dead_time(dead_time),
        .gates_o(gate_o), .level_o(level_out)
    );

    assign level_o = level_out;

endmodule

// File: tb/mlpwm_modulator_tb_top.sv
// Directed bench for the seven-level multicarrier modulator.
module mlpwm_modulator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic [7:0]  mod_idx = 8'd0;
    logic [31:0] sine_inc = '0;
    logic [31:0] car_inc = '0;
    logic [7:0]  dead_time = '0;
    logic [4:0]  gate_o;
    logic [2:0]  level_o;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [31:0] CAR64 = 32'h0400_0000;  // 64-clock carrier period
    localparam logic [31:0] PH90  = 32'h4000_0000;
    localparam logic [31:0] PH270 = 32'hC000_0000;

    always #5 clk = ~clk;

    mlpwm_modulator dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_sel(mode_sel),
        .mod_idx(mod_idx), .sine_inc(sine_inc), .car_inc(car_inc),
        .dead_time(dead_time), .gate_o(gate_o), .level_o(level_o)
    );

    function automatic int lvl();
        return int'($signed(level_o));
    endfunction

    // Expected gates from the R8 table, {S5,S4,S3,S2,S1}.
    function automatic int exp_gates(input int l);
        case (l)
            1:  return 5'b10100;
            2:  return 5'b10010;
            3:  return 5'b10001;
            -1: return 5'b01001;
            -2: return 5'b01010;
            -3: return 5'b01100;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Freeze the reference at a quarter-phase point, then start the carrier.
    task automatic setup_const(input logic [1:0] md, input logic [31:0] ph, input logic [7:0] mi);
        en = 1'b0; mode_sel = md; mod_idx = mi; sine_inc = ph; car_inc = CAR64;
        dead_time = 8'd0;
        cycles(3);
        en = 1'b1;
        cycles(1);
        sine_inc = '0;
    endtask

    task automatic t_reset();
        en = 1'b1; sine_inc = 32'h0020_0000; car_inc = CAR64; mod_idx = 8'd255;
        cycles(6);
        check(gate_o == 0, "R1 gates in reset", int'(gate_o), 0);
        check(lvl() == 0, "R1 level in reset", lvl(), 0);
        rst_n = 1'b1;
        en = 1'b0;
        cycles(2);
    endtask

    // Early/late readings of one period for a given arrangement and reference.
    task automatic t_arrangement(input logic [1:0] md, input logic [31:0] ph, input logic [7:0] mi,
                                 input int early, input int late, input string tag);
        setup_const(md, ph, mi);
        cycles(9);
        check(lvl() == early, {tag, " early"}, lvl(), early);
        cycles(14);
        check(lvl() == late, {tag, " late"}, lvl(), late);
    endtask

    task automatic t_duty();
        int n3 = 0;
        int nother = 0;
        setup_const(2'd0, PH90, 8'd213);
        cycles(10);
        for (int i = 0; i < 64; i++) begin
            cycles(1);
            if (lvl() == 3) n3++;
            else if (lvl() != 2) nother++;
        end
        check(nother == 0, "R6 only levels 2 and 3 at constant ref", nother, 0);
        check(n3 >= 28 && n3 <= 34, "R6 duty of level 3", n3, 31);
    endtask

    task automatic t_mode_latch();
        setup_const(2'd0, PH90, 8'd213);
        cycles(5);
        mode_sel = 2'd2;
        cycles(6);
        check(lvl() == 3, "R7 old arrangement kept mid-period", lvl(), 3);
        cycles(62);
        check(lvl() == 2, "R7 new arrangement after wrap", lvl(), 2);
    endtask

    task automatic t_full_sine();
        int last = 0;
        int left = 0;
        int bad_tab = 0;
        int bad_pol = 0;
        int bad_leg = 0;
        int windows = 0;
        bit seen_p3 = 0;
        bit seen_n3 = 0;
        en = 1'b0; mode_sel = 2'd1; mod_idx = 8'd255;
        sine_inc = 32'h0020_0000; car_inc = CAR64; dead_time = 8'd5;
        cycles(3);
        en = 1'b1;
        for (int i = 0; i < 4200; i++) begin
            int l;
            int sg;
            int eg;
            cycles(1);
            l  = lvl();
            sg = (l > 0) ? 1 : ((l < 0) ? -1 : 0);
            if (sg != 0 && last != 0 && sg != last) begin
                left = int'(dead_time);
                windows++;
            end
            eg = exp_gates(l);
            if (left > 0) eg = eg & 5'b00111;
            if (int'(gate_o) != eg) bad_tab++;
            if (gate_o[4] && gate_o[3]) bad_pol++;
            if (l != 0 && $countones(gate_o[2:0]) != 1) bad_leg++;
            if (left > 0) left--;
            if (sg != 0) last = sg;
            if (l == 3) seen_p3 = 1;
            if (l == -3) seen_n3 = 1;
        end
        check(bad_tab == 0, "R8 gate pattern versus level table with R10 blanking", bad_tab, 0);
        check(bad_pol == 0, "R9 S4 and S5 together", bad_pol, 0);
        check(bad_leg == 0, "R9 one step switch per nonzero level", bad_leg, 0);
        check(windows >= 2, "R10 blanking windows seen", windows, 2);
        check(seen_p3 && seen_n3, "R11 both extreme levels reached", int'(seen_p3) + int'(seen_n3), 2);
        en = 1'b0;
        cycles(1);
        check(gate_o == 0, "R1 gates after enable low", int'(gate_o), 0);
        check(lvl() == 0, "R1 level after enable low", lvl(), 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cycles(1);
        t_reset();
        // R3/R1: positive ref 2555 lies in band 5; phases restart from zero.
        t_arrangement(2'd0, PH90,  8'd213, 3, 2,   "R3 in-phase positive");
        t_arrangement(2'd0, PH270, 8'd128, -1, -2, "R3 in-phase negative");
        t_arrangement(2'd3, PH270, 8'd128, -1, -2, "R3 spare code as in-phase");
        t_arrangement(2'd1, PH90,  8'd213, 3, 2,   "R4 mirrored positive");
        t_arrangement(2'd1, PH270, 8'd128, -2, -1, "R4 mirrored negative");
        t_arrangement(2'd2, PH90,  8'd213, 2, 3,   "R5 alternating positive");
        t_arrangement(2'd2, PH270, 8'd128, -2, -1, "R5 alternating negative");
        t_duty();
        t_mode_latch();
        t_full_sine();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule